// File: doc/BRIEF.md
# Periodic Refresh Scheduler

This block keeps a synchronous DRAM's contents alive by issuing auto-refresh commands at a steady average rate. A free-running interval counter produces one refresh obligation per interval, where the interval is derived at elaboration time from the clock frequency, the retention window and the number of refresh commands that window demands, less a small safety margin. Obligations accumulate in a saturating pending counter. While any are outstanding, the block raises a request toward the command sequencer. When the pending counter is full, it also raises an urgent flag.

When the sequencer grants the command bus, the block runs one refresh sequence. It first sends a precharge of every bank, then waits out the precharge time and sends the auto-refresh command. It then holds the bus with no-operation commands for the full row cycle time. At the end it hands the bus back with a single-cycle done pulse, and the pending count drops by one. The command strobes are driven only while the grant is high. At all other times they show a deselect. The sequencer keeps the clock enable high and must hold the grant until done.

Top module: `refresh_pacer`

## Requirements
- R1: After reset is released, the request first rises exactly PERIOD_CLKS rising edges later. PERIOD_CLKS = floor(CLK_MHZ*WINDOW_US/ROWS) - MARGIN_CLKS, which is 3890 with the defaults (250 MHz, 32000 us, 2048 rows, margin 16).
- R2: One obligation is added every PERIOD_CLKS edges. The pending count saturates at MAX_PEND (8), and extra intervals are lost. The urgent flag is high exactly when the count equals MAX_PEND.
- R3: The request is high exactly while the pending count is non-zero.
- R4: Suppose the request and the grant are both high at a rising edge while the block is idle. In the next cycle the block drives precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. Exactly TRP_CLKS = ceil(TRP_NS*CLK_MHZ/1000) cycles after that (5 by default), it drives auto-refresh: cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0. The cycles in between carry NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0.
- R5: After the refresh cycle, only NOP is driven for TRC_CLKS-1 cycles, where TRC_CLKS = ceil(TRC_NS*CLK_MHZ/1000) (15 by default). Done is then high for exactly one cycle, TRC_CLKS cycles after the refresh, and that cycle carries NOP.
- R6: Busy is high from the precharge cycle through the last cycle before done, and low otherwise.
- R7: While the grant is low, the strobes show deselect: all four strobes high and a10=0.
- R8: Each completed sequence lowers the pending count by one, and the new count is already visible in the done cycle. When the count falls below MAX_PEND, urgent drops.
- R9: During reset and right after it, the strobes show deselect, and request, urgent, busy and done are low.
- R10: A grant while nothing is pending starts no sequence. The strobes stay deselected and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_grant | input | 1 | Sequencer hands the command bus to this block |
| cmd_cs_n | output | 1 | Chip select strobe, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write strobe, active low |
| cmd_a10 | output | 1 | Address bit 10, high selects all banks on precharge |
| ref_req | output | 1 | At least one refresh is pending |
| ref_urgent | output | 1 | Pending count has reached its limit |
| ref_busy | output | 1 | A refresh sequence owns the bus |
| ref_done | output | 1 | One-cycle pulse as the bus is released |

## Verification
The first request is timed edge by edge from reset release. That separates a correct interval from one that is off by one or built with the wrong rounding. A single pending refresh is granted and drained, which pins the precharge-to-refresh gap, the length of the NOP hold and the position of the done pulse. A grant while nothing is pending must start nothing. The counter is then left to fill over many intervals, with probes just before and just after the eighth. Once full, the block is drained with eight back-to-back grants. This tells a counter that saturates correctly apart from one that wraps or keeps counting, and shows urgent dropping on the first completion.

// File: rtl/refp_pkg.sv
`timescale 1ns/1ps
package refp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WRP,
      ST_REF,
      ST_WRC,
      ST_DONE
   } refp_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
      logic a10;
   } refp_cmd_t;

   localparam refp_cmd_t CMD_DESEL  = 5'b11110;
   localparam refp_cmd_t CMD_NOP    = 5'b01110;
   localparam refp_cmd_t CMD_PREALL = 5'b00101;
   localparam refp_cmd_t CMD_REFR   = 5'b00010;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/refp_interval.sv
`timescale 1ns/1ps
module refp_interval #(
   parameter int PERIOD_CLKS = 3890
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = $clog2(PERIOD_CLKS);

   logic [CW-1:0] cnt;

   assign tick = (cnt == CW'(PERIOD_CLKS - 1));

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/refp_pending.sv
`timescale 1ns/1ps
module refp_pending #(
   parameter int MAX_PEND = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic inc,
   input  logic dec,
   output logic nz,
   output logic full
);
   generate
      if (MAX_PEND == 1) begin : g_flag
         logic flag;
         always_ff @(posedge clk) begin
            if (rst)      flag <= 1'b0;
            else if (inc) flag <= 1'b1;
            else if (dec) flag <= 1'b0;
         end
         assign nz   = flag;
         assign full = flag;
      end else begin : g_cnt
         localparam int PW = $clog2(MAX_PEND + 1);
         logic [PW-1:0] cnt;
         logic          up, dn;
         assign full = (cnt == PW'(MAX_PEND));
         assign nz   = (cnt != '0);
         assign up   = inc && (!full || dec);
         assign dn   = dec && nz;
         always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else begin
               case ({up, dn})
                  2'b10:   cnt <= cnt + 1'b1;
                  2'b01:   cnt <= cnt - 1'b1;
                  default: cnt <= cnt;
               endcase
            end
         end
      end
   endgenerate
endmodule

// File: rtl/refp_seq.sv
`timescale 1ns/1ps
module refp_seq
   import refp_pkg::*;
#(
   parameter int TRP_CLKS = 5,
   parameter int TRC_CLKS = 15
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      grant,
   input  logic      pend_nz,
   output refp_cmd_t cmd,
   output logic      busy,
   output logic      done,
   output logic      fin
);
   localparam int TMAX    = (TRP_CLKS > TRC_CLKS) ? TRP_CLKS : TRC_CLKS;
   localparam int TW      = $clog2(TMAX + 1);
   localparam bit SKIP_RP = (TRP_CLKS < 2);
   localparam int RP_LAST = SKIP_RP ? 0 : TRP_CLKS - 2;
   localparam int RC_LAST = TRC_CLKS - 2;

   refp_state_e   st;
   logic [TW-1:0] tmr;

   assign fin = (st == ST_WRC) && (tmr == TW'(RC_LAST));

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_IDLE;
         tmr <= '0;
      end else begin
         case (st)
            ST_IDLE: if (grant && pend_nz) st <= ST_PRE;
            ST_PRE: begin
               st  <= SKIP_RP ? ST_REF : ST_WRP;
               tmr <= '0;
            end
            ST_WRP: begin
               if (tmr == TW'(RP_LAST)) st <= ST_REF;
               else                     tmr <= tmr + 1'b1;
            end
            ST_REF: begin
               st  <= ST_WRC;
               tmr <= '0;
            end
            ST_WRC: begin
               if (fin) st <= ST_DONE;
               else     tmr <= tmr + 1'b1;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_PRE:  cmd = CMD_PREALL;
         ST_REF:  cmd = CMD_REFR;
         ST_WRP,
         ST_WRC,
         ST_DONE: cmd = CMD_NOP;
         default: cmd = CMD_DESEL;
      endcase
   end

   assign busy = (st == ST_PRE) || (st == ST_WRP) || (st == ST_REF) || (st == ST_WRC);
   assign done = (st == ST_DONE);
endmodule

// File: rtl/refresh_pacer.sv
`timescale 1ns/1ps
module refresh_pacer
   import refp_pkg::*;
#(
   parameter int CLK_MHZ     = 250,
   parameter int WINDOW_US   = 32000,
   parameter int ROWS        = 2048,
   parameter int MARGIN_CLKS = 16,
   parameter int TRP_NS      = 18,
   parameter int TRC_NS      = 60,
   parameter int MAX_PEND    = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic bus_grant,
   output logic cmd_cs_n,
   output logic cmd_ras_n,
   output logic cmd_cas_n,
   output logic cmd_we_n,
   output logic cmd_a10,
   output logic ref_req,
   output logic ref_urgent,
   output logic ref_busy,
   output logic ref_done
);
   localparam int PERIOD_CLKS = (CLK_MHZ * WINDOW_US) / ROWS - MARGIN_CLKS;
   localparam int TRP_CLKS    = ceil_div(TRP_NS * CLK_MHZ, 1000);
   localparam int TRC_CLKS    = ceil_div(TRC_NS * CLK_MHZ, 1000);

   generate
      if (PERIOD_CLKS < 2 * (TRP_CLKS + TRC_CLKS + 2)) begin : g_bad_period
         $error("refresh interval too short for one refresh sequence");
      end
      if (TRC_CLKS < 2) begin : g_bad_trc
         $error("row cycle time must span at least two clocks");
      end
      if (TRP_CLKS < 1) begin : g_bad_trp
         $error("precharge time must span at least one clock");
      end
      if (MAX_PEND < 1) begin : g_bad_pend
         $error("pending limit must be at least one");
      end
   endgenerate

   logic      tick, fin, pend_nz, pend_full;
   refp_cmd_t seq_cmd, bus_cmd;

   refp_interval #(.PERIOD_CLKS(PERIOD_CLKS)) u_intv (
      .clk (clk),
      .rst (rst),
      .tick(tick)
   );

   refp_pending #(.MAX_PEND(MAX_PEND)) u_pend (
      .clk (clk),
      .rst (rst),
      .inc (tick),
      .dec (fin),
      .nz  (pend_nz),
      .full(pend_full)
   );

   refp_seq #(.TRP_CLKS(TRP_CLKS), .TRC_CLKS(TRC_CLKS)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .grant  (bus_grant),
      .pend_nz(pend_nz),
      .cmd    (seq_cmd),
      .busy   (ref_busy),
      .done   (ref_done),
      .fin    (fin)
   );

   assign bus_cmd    = bus_grant ? seq_cmd : CMD_DESEL;
   assign cmd_cs_n   = bus_cmd.cs_n;
   assign cmd_ras_n  = bus_cmd.ras_n;
   assign cmd_cas_n  = bus_cmd.cas_n;
   assign cmd_we_n   = bus_cmd.we_n;
   assign cmd_a10    = bus_cmd.a10;
   assign ref_req    = pend_nz;
   assign ref_urgent = pend_full;
endmodule

// File: rtl/refp_chk.sv
`timescale 1ns/1ps
module refp_chk #(
   parameter int TRP_CLKS = 5,
   parameter int TRC_CLKS = 15
) (
   input logic clk,
   input logic rst,
   input logic bus_grant,
   input logic cmd_cs_n,
   input logic cmd_ras_n,
   input logic cmd_cas_n,
   input logic cmd_we_n,
   input logic cmd_a10,
   input logic ref_req,
   input logic ref_urgent,
   input logic ref_busy,
   input logic ref_done
);
   logic        is_pre, is_ref, is_quiet;
   logic [15:0] since_pre, since_ref;

   assign is_pre   = !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n && cmd_a10;
   assign is_ref   = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n;
   assign is_quiet = cmd_cs_n || (cmd_ras_n && cmd_cas_n && cmd_we_n);

   always_ff @(posedge clk) begin
      if (rst) begin
         since_pre <= '1;
         since_ref <= '1;
      end else begin
         if (is_pre)                since_pre <= 16'd1;
         else if (since_pre != '1) since_pre <= since_pre + 16'd1;
         if (is_ref)                since_ref <= 16'd1;
         else if (since_ref != '1) since_ref <= since_ref + 16'd1;
      end
   end

   p_ref_after_pre_r4: assert property (@(posedge clk) disable iff (rst)
      is_ref |-> (since_pre == 16'(TRP_CLKS)));

   p_quiet_after_ref_r5: assert property (@(posedge clk) disable iff (rst)
      (since_ref < 16'(TRC_CLKS)) |-> is_quiet);

   p_done_at_trc_r5: assert property (@(posedge clk) disable iff (rst)
      ref_done |-> (since_ref == 16'(TRC_CLKS)));

   p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
      ref_done |=> !ref_done);

   p_urgent_has_req_r2: assert property (@(posedge clk) disable iff (rst)
      ref_urgent |-> ref_req);

   p_deselect_no_grant_r7: assert property (@(posedge clk) disable iff (rst)
      !bus_grant |-> cmd_cs_n);

   p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ref_busy) |-> ($past(bus_grant) && $past(ref_req)));

   p_no_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (!ref_req && !ref_busy && !ref_done) |=> !ref_busy);
endmodule

bind refresh_pacer refp_chk #(.TRP_CLKS(TRP_CLKS), .TRC_CLKS(TRC_CLKS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_grant (bus_grant),
   .cmd_cs_n  (cmd_cs_n),
   .cmd_ras_n (cmd_ras_n),
   .cmd_cas_n (cmd_cas_n),
   .cmd_we_n  (cmd_we_n),
   .cmd_a10   (cmd_a10),
   .ref_req   (ref_req),
   .ref_urgent(ref_urgent),
   .ref_busy  (ref_busy),
   .ref_done  (ref_done)
);

// File: tb/sim_refresh_pacer.sv
`timescale 1ns/1ps
module sim_refresh_pacer;
   localparam int P   = (250 * 32000) / 2048 - 16;
   localparam int TRP = (18 * 250 + 999) / 1000;
   localparam int TRC = (60 * 250 + 999) / 1000;

   // {cs_n, ras_n, cas_n, we_n, a10, busy, done}
   localparam logic [6:0] E_IDLE = 7'b1111000;
   localparam logic [6:0] E_PRE  = 7'b0010110;
   localparam logic [6:0] E_NOPB = 7'b0111010;
   localparam logic [6:0] E_REF  = 7'b0001010;
   localparam logic [6:0] E_DONE = 7'b0111001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic grant = 1'b0;
   logic cs_n, ras_n, cas_n, we_n, a10, req, urgent, busy, done;

   int   n_chk = 0;
   int   n_bad = 0;
   int   ecount = 0;
   bit   finished = 0;

   logic [6:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   refresh_pacer u0 (
      .clk       (clk),
      .rst       (rst),
      .bus_grant (grant),
      .cmd_cs_n  (cs_n),
      .cmd_ras_n (ras_n),
      .cmd_cas_n (cas_n),
      .cmd_we_n  (we_n),
      .cmd_a10   (a10),
      .ref_req   (req),
      .ref_urgent(urgent),
      .ref_busy  (busy),
      .ref_done  (done)
   );

   always @(posedge clk) begin
      if (rst) ecount <= 0;
      else     ecount <= ecount + 1;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, ecount);
      end
   endtask

   // monitor: pops scoreboard items, otherwise expects an idle bus
   always @(negedge clk) begin
      logic [6:0] obs;
      obs = {cs_n, ras_n, cas_n, we_n, a10, busy, done};
      if (exp_q.size() > 0) begin
         logic [6:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, int'(obs), int'(e));
      end else if (!finished) begin
         if (rst)         check("R9 idle bus in reset", int'(obs), int'(E_IDLE));
         else if (!grant) check("R7 deselect without grant", int'(obs), int'(E_IDLE));
         else             check("R10 grant with nothing pending", int'(obs), int'(E_IDLE));
      end
   end

   // driver: grants the bus and pushes the expected sequence
   task automatic run_refresh();
      @(negedge clk);
      #1 grant = 1'b1;
      @(posedge clk);
      exp_q.push_back(E_PRE);  tag_q.push_back("R4 precharge-all");
      for (int i = 0; i < TRP - 1; i++) begin
         exp_q.push_back(E_NOPB); tag_q.push_back("R4 nop before refresh");
      end
      exp_q.push_back(E_REF);  tag_q.push_back("R4 refresh");
      for (int i = 0; i < TRC - 1; i++) begin
         exp_q.push_back(E_NOPB); tag_q.push_back("R5 nop hold R6 busy");
      end
      exp_q.push_back(E_DONE); tag_q.push_back("R5 done pulse");
      repeat (TRP + TRC + 1) @(negedge clk);
      #1 grant = 1'b0;
   endtask

   task automatic wait_edge(input int target);
      while (ecount < target) @(negedge clk);
   endtask

   initial begin
      int k;
      repeat (5) @(negedge clk);
      check("R9 req in reset", int'(req), 0);
      check("R9 urgent in reset", int'(urgent), 0);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R9 busy after reset", int'(busy), 0);
      check("R9 done after reset", int'(done), 0);
      k = 1;
      while (!req && k < P + 5) begin
         @(negedge clk);
         k++;
      end
      check("R1 first request edge", k, P);
      check("R2 urgent with one pending", int'(urgent), 0);

      run_refresh();
      @(negedge clk);
      check("R8 req after single drain", int'(req), 0);
      check("R3 req low when empty", int'(req), 0);

      @(negedge clk);
      #1 grant = 1'b1;
      repeat (20) @(negedge clk);
      check("R10 busy with nothing pending", int'(busy), 0);
      #1 grant = 1'b0;

      wait_edge(8 * P + 10);
      check("R2 urgent at seven pending", int'(urgent), 0);
      check("R3 req with seven pending", int'(req), 1);
      wait_edge(9 * P + 10);
      check("R2 urgent at eight pending", int'(urgent), 1);
      wait_edge(11 * P + 10);
      check("R2 urgent held when saturated", int'(urgent), 1);
      wait_edge(12 * P + 2);

      for (int i = 0; i < 8; i++) begin
         run_refresh();
         @(negedge clk);
         check("R8 urgent after drain", int'(urgent), 0);
         check("R2 R3 req after drain", int'(req), (i < 7) ? 1 : 0);
      end

      repeat (3) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(150000 * 4);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired at edge %0d", ecount);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule